// File: doc/BRIEF.md
# 64B/66B Receive Block Aligner and Descrambler

This block sits behind a receive gearbox that delivers one 66-bit line block per clock: a 2-bit sync header beside 64 payload bits. While not aligned, it checks every header and asks the gearbox to shift by one candidate position whenever it sees a header that cannot be legal. Once it has seen enough legal headers in a row, it declares alignment. From then on it watches the header error rate to decide whether alignment is lost and whether the line has a high bit error rate.

The payload passes through a self-synchronizing descrambler built on the polynomial x^58 + x^39 + 1. The descrambled word, the header and the alignment flag leave the block one cycle after the block arrives. A matching scrambler for the transmit direction is included so that a transmit stream can be looped straight back into the receive side. Control-character decoding, the gearbox and clock-domain crossing belong to other blocks.

Top module: `line_block_sync`

## Requirements
- R1: While reset is applied, and in the first cycle after it, `rx_slip`, `out_lock`, `out_hi_ber`, `out_hdr`, `out_data` and `tx_scr` are all zero.
- R2: A header is legal only when it is 2'b01 or 2'b10. When the block is unaligned and not waiting, the 64th legal header in a row raises `out_lock` one cycle after that block arrives.
- R3: When the block is unaligned and not waiting, an illegal header (2'b00 or 2'b11) raises `rx_slip` in the next cycle for exactly one cycle. It also clears the count of legal headers, so 64 fresh legal headers are needed.
- R4: The 4 blocks after a slip are ignored. Their headers raise no slip and count toward nothing. The block after them is checked again.
- R5: While aligned, blocks are grouped into 64-block windows. The first window starts with the first aligned block. The 16th illegal header inside one window drops `out_lock` in the next cycle, and the error count is cleared at the end of each window.
- R6: `out_hdr` copies the received header one cycle later in every state. `out_data` carries the descrambled word one cycle later when the block is aligned after that block, and is zero otherwise.
- R7: Descrambling takes the payload LSB first: plain[i] = s[i] ^ s[i-39] ^ s[i-58]. Here s is the stream of received scrambled bits, and the history is carried across words. Whatever the history held before, the second word after any corrupted word comes out correctly.
- R8: `tx_scr` is the scrambled form of `tx_data`, one cycle later: out[i] = d[i] ^ out[i-39] ^ out[i-58]. It draws on the block's own earlier output bits, and its history is zero after reset.
- R9: The high-error-rate monitor runs only while aligned, using 48828-block windows that start with the first aligned block. `out_hi_ber` rises one cycle after the 16th illegal header in a window, stays high until the end of that window, and is zero whenever `out_lock` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_hdr | input | 2 | Sync header of the incoming block |
| rx_data | input | 64 | Scrambled payload of the incoming block |
| rx_slip | output | 1 | One-cycle request to move the gearbox to its next alignment |
| out_hdr | output | 2 | Registered copy of the received header |
| out_data | output | 64 | Descrambled payload, zero while unaligned |
| out_lock | output | 1 | Block alignment achieved |
| out_hi_ber | output | 1 | High header error rate seen in the current window |
| tx_data | input | 64 | Transmit payload to scramble |
| tx_scr | output | 64 | Scrambled transmit payload |

## Verification
The bench goes after the off-by-one edges of the counters. It checks that 63 legal headers do not lock and the 64th does. It checks that a slip is followed by exactly four ignored blocks, and that 15 errors in a window keep alignment while the 16th drops it. An error count that missed its window clear would lose alignment on errors spread over two windows. A monitor that ran while unaligned, or never cleared at the end of its 48828-block window, would leave the high-error flag stuck. A descrambler whose tap positions or bit order were wrong would corrupt the looped-back payload. One that did not resynchronize would still be wrong two words after an injected corrupted word.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
    localparam int WORD_W   = 64;   // payload bits per block
    localparam int HIST_W   = 58;   // highest polynomial term
    localparam int TAP_NEAR = 39;   // middle polynomial term

    // legal sync header: the two bits differ
    function automatic logic hdr_ok(input logic [1:0] h);
        return h[0] ^ h[1];
    endfunction
endpackage

// File: rtl/lbs_lock_fsm.sv
module lbs_lock_fsm #(
    parameter int LOCK_GOOD = 64,
    parameter int SLIP_WAIT = 4,
    parameter int LOSS_WIN  = 64,
    parameter int LOSS_BAD  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hdr_valid,
    output logic lock,
    output logic lock_nxt,
    output logic slip
);
    localparam int GW = $clog2(LOCK_GOOD + 1);
    localparam int WW = $clog2(SLIP_WAIT + 2);
    localparam int LW = $clog2(LOSS_WIN);
    localparam int BW = $clog2(LOSS_BAD + 1);

    typedef struct packed {
        logic          locked;
        logic          slip;
        logic [GW-1:0] good;
        logic [WW-1:0] hold;
        logic [LW-1:0] win;
        logic [BW-1:0] bad;
    } lock_st_t;

    lock_st_t st_d, st_q;
    logic [BW-1:0] bad_sum;

    always_comb begin
        st_d      = st_q;
        st_d.slip = 1'b0;
        bad_sum   = st_q.bad + {{(BW-1){1'b0}}, ~hdr_valid};
        if (!st_q.locked) begin
            st_d.win = '0;
            st_d.bad = '0;
            if (st_q.hold != '0) begin
                st_d.hold = st_q.hold - 1'b1;           // block ignored
            end else if (!hdr_valid) begin
                st_d.slip = 1'b1;
                st_d.good = '0;
                st_d.hold = WW'(SLIP_WAIT);
            end else if (st_q.good == GW'(LOCK_GOOD - 1)) begin
                st_d.locked = 1'b1;
                st_d.good   = '0;
            end else begin
                st_d.good = st_q.good + 1'b1;
            end
        end else begin
            if (bad_sum == BW'(LOSS_BAD)) begin
                st_d.locked = 1'b0;
                st_d.win    = '0;
                st_d.bad    = '0;
            end else if (st_q.win == LW'(LOSS_WIN - 1)) begin
                st_d.win = '0;
                st_d.bad = '0;
            end else begin
                st_d.win = st_q.win + 1'b1;
                st_d.bad = bad_sum;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lock     = st_q.locked;
    assign lock_nxt = st_d.locked;
    assign slip     = st_q.slip;
endmodule

// File: rtl/lbs_ber_mon.sv
module lbs_ber_mon #(
    parameter int WIN = 48828,
    parameter int BAD = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic hdr_valid,
    output logic hi_ber
);
    localparam int WW = $clog2(WIN);
    localparam int BW = $clog2(BAD + 2);

    typedef struct packed {
        logic [WW-1:0] win;
        logic [BW-1:0] bad;
        logic          flag;
    } ber_st_t;

    ber_st_t st_d, st_q;
    logic [BW-1:0] bad_sum;

    always_comb begin
        st_d    = st_q;
        bad_sum = st_q.bad + {{(BW-1){1'b0}}, ~hdr_valid};
        if (!en) begin
            st_d = '0;
        end else if (st_q.win == WW'(WIN - 1)) begin
            st_d = '0;                                   // window ends
        end else begin
            st_d.win = st_q.win + 1'b1;
            st_d.bad = (st_q.bad == BW'(BAD)) ? st_q.bad : bad_sum;
            if (bad_sum == BW'(BAD)) st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hi_ber = st_q.flag;
endmodule

// File: rtl/lbs_descrambler.sv
module lbs_descrambler
    import lbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [1:0]        in_hdr,
    input  logic [WORD_W-1:0] in_data,
    output logic [1:0]        out_hdr,
    output logic [WORD_W-1:0] out_data
);
    localparam int EXT_W = WORD_W + HIST_W;

    typedef struct packed {
        logic [HIST_W-1:0] hist;
        logic [1:0]        hdr;
        logic [WORD_W-1:0] data;
    } dsc_st_t;

    dsc_st_t st_d, st_q;
    logic [EXT_W-1:0]  ext;
    logic [WORD_W-1:0] plain;

    always_comb begin
        ext = {in_data, st_q.hist};
        for (int i = 0; i < WORD_W; i++) begin
            plain[i] = ext[i + HIST_W] ^ ext[i + HIST_W - TAP_NEAR] ^ ext[i];
        end
        st_d.hist = ext[EXT_W-1:WORD_W];
        st_d.hdr  = in_hdr;
        st_d.data = en ? plain : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_hdr  = st_q.hdr;
    assign out_data = st_q.data;
endmodule

// File: rtl/lbs_scrambler.sv
module lbs_scrambler
    import lbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] in_data,
    output logic [WORD_W-1:0] out_data
);
    localparam int EXT_W = WORD_W + HIST_W;

    typedef struct packed {
        logic [HIST_W-1:0] hist;
        logic [WORD_W-1:0] data;
    } scr_st_t;

    scr_st_t st_d, st_q;
    logic [EXT_W-1:0] ext;

    always_comb begin
        ext[HIST_W-1:0] = st_q.hist;
        for (int i = 0; i < WORD_W; i++) begin
            ext[i + HIST_W] = in_data[i] ^ ext[i + HIST_W - TAP_NEAR] ^ ext[i];
        end
        st_d.hist = ext[EXT_W-1:WORD_W];
        st_d.data = ext[EXT_W-1:HIST_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_data = st_q.data;
endmodule

// File: rtl/line_block_sync.sv
module line_block_sync
    import lbs_pkg::*;
#(
    parameter int LOCK_GOOD = 64,
    parameter int SLIP_WAIT = 4,
    parameter int LOSS_WIN  = 64,
    parameter int LOSS_BAD  = 16,
    parameter int BER_WIN   = 48828,
    parameter int BER_BAD   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        rx_hdr,
    input  logic [WORD_W-1:0] rx_data,
    output logic              rx_slip,
    output logic [1:0]        out_hdr,
    output logic [WORD_W-1:0] out_data,
    output logic              out_lock,
    output logic              out_hi_ber,
    input  logic [WORD_W-1:0] tx_data,
    output logic [WORD_W-1:0] tx_scr
);
    logic hdr_good;
    logic lock_nxt;

    assign hdr_good = hdr_ok(rx_hdr);

    lbs_lock_fsm #(
        .LOCK_GOOD(LOCK_GOOD), .SLIP_WAIT(SLIP_WAIT),
        .LOSS_WIN(LOSS_WIN),   .LOSS_BAD(LOSS_BAD)
    ) u_lock (
        .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_good),
        .lock(out_lock), .lock_nxt(lock_nxt), .slip(rx_slip)
    );

    lbs_ber_mon #(.WIN(BER_WIN), .BAD(BER_BAD)) u_ber (
        .clk(clk), .rst_n(rst_n), .en(out_lock & lock_nxt),
        .hdr_valid(hdr_good), .hi_ber(out_hi_ber)
    );

    lbs_descrambler u_dsc (
        .clk(clk), .rst_n(rst_n), .en(lock_nxt),
        .in_hdr(rx_hdr), .in_data(rx_data),
        .out_hdr(out_hdr), .out_data(out_data)
    );

    lbs_scrambler u_scr (
        .clk(clk), .rst_n(rst_n), .in_data(tx_data), .out_data(tx_scr)
    );
endmodule

// File: rtl/line_block_sync_chk.sv
module lbs_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  rx_hdr,
    input logic        rx_slip,
    input logic        out_lock,
    input logic        out_hi_ber,
    input logic [63:0] out_data
);
    a_r3_slip_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_slip |=> !rx_slip);

    a_r3_slip_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        rx_slip |-> !out_lock);

    a_r9_ber_in_lock: assert property (@(posedge clk) disable iff (!rst_n)
        out_hi_ber |-> out_lock);

    a_r6_zero_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        !out_lock |-> (out_data == 64'd0));

    a_r2_lock_on_legal: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_lock) |-> ($past(rx_hdr) == 2'b01 || $past(rx_hdr) == 2'b10));

    a_r5_loss_on_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_lock) |-> ($past(rx_hdr) == 2'b00 || $past(rx_hdr) == 2'b11));
endmodule

bind line_block_sync lbs_checker u_chk (
    .clk(clk), .rst_n(rst_n), .rx_hdr(rx_hdr), .rx_slip(rx_slip),
    .out_lock(out_lock), .out_hi_ber(out_hi_ber), .out_data(out_data)
);

// File: tb/line_block_sync_test.sv
`timescale 1ns/1ps
module line_block_sync_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  rx_hdr = 2'b00;
    logic [63:0] rx_data = '0;
    logic [63:0] tx_data = '0;
    logic        rx_slip, out_lock, out_hi_ber;
    logic [1:0]  out_hdr;
    logic [63:0] out_data, tx_scr;

    int n_chk = 0;
    int n_err = 0;
    int lk = 0;                 // index of next block counted from first aligned block
    logic [57:0] tx_hist = '0;
    logic [57:0] rx_hist = '0;
    logic [63:0] exp_plain;     // bench descramble of the last block
    logic [63:0] last_plain;    // payload sent in the last step

    always #2.5 clk = ~clk;

    line_block_sync uut (
        .clk(clk), .rst_n(rst_n), .rx_hdr(rx_hdr), .rx_data(rx_data),
        .rx_slip(rx_slip), .out_hdr(out_hdr), .out_data(out_data),
        .out_lock(out_lock), .out_hi_ber(out_hi_ber),
        .tx_data(tx_data), .tx_scr(tx_scr)
    );

    // {hdr, payload}; every header legal
    localparam logic [65:0] VEC [8] = '{
        {2'b01, 64'h0000_0000_0000_0000},
        {2'b10, 64'hFFFF_FFFF_FFFF_FFFF},
        {2'b01, 64'h0123_4567_89AB_CDEF},
        {2'b10, 64'h8000_0000_0000_0001},
        {2'b01, 64'hDEAD_BEEF_CAFE_F00D},
        {2'b10, 64'h5555_AAAA_5555_AAAA},
        {2'b01, 64'h0000_0000_0000_0080},
        {2'b10, 64'hFEDC_BA98_7654_3210}
    };

    function automatic logic [63:0] scr_word(input logic [63:0] p, input logic [57:0] h);
        logic [121:0] e;
        e[57:0] = h;
        for (int i = 0; i < 64; i++) e[i+58] = p[i] ^ e[i+19] ^ e[i];
        return e[121:58];
    endfunction

    function automatic logic [63:0] dsc_word(input logic [63:0] d, input logic [57:0] h);
        logic [121:0] e;
        logic [63:0]  o;
        e = {d, h};
        for (int i = 0; i < 64; i++) o[i] = e[i+58] ^ e[i+19] ^ e[i];
        return o;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one block per call: drive after a falling edge, sample at the next one
    task automatic step(input logic [1:0] h, input logic [63:0] p, input logic junk);
        logic [63:0] s;
        s = scr_word(p, tx_hist);
        rx_hdr  = h;
        tx_data = p;
        rx_data = junk ? (p ^ 64'h3C96_A50F_E187_7B24) : s;
        @(negedge clk);
        check("R8 tx scramble", tx_scr, s);
        tx_hist    = s[63:6];
        exp_plain  = dsc_word(rx_data, rx_hist);
        rx_hist    = rx_data[63:6];
        last_plain = p;
        if (out_lock) lk++;
    endtask

    function automatic logic [63:0] pat(input int k);
        return 64'h9E37_79B9_7F4A_7C15 * 64'(k + 1);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 slip", {63'd0, rx_slip}, 64'd0);
        check("R1 lock", {63'd0, out_lock}, 64'd0);
        check("R1 hi_ber", {63'd0, out_hi_ber}, 64'd0);
        check("R1 data", out_data, 64'd0);
        check("R1 tx", tx_scr, 64'd0);
        rst_n = 1'b1;
        step(2'b01, 64'd0, 1'b0);
        check("R1 first cycle hdr", {62'd0, out_hdr}, 64'd1);
        check("R1 first cycle lock", {63'd0, out_lock}, 64'd0);

        // R3: illegal header slips next cycle
        step(2'b00, pat(1), 1'b0);
        check("R3 slip on 00", {63'd0, rx_slip}, 64'd1);
        // R4: four ignored blocks, even with illegal headers
        for (int k = 0; k < 4; k++) begin
            step(2'b11, pat(k), 1'b0);
            check("R4 ignored block no slip", {63'd0, rx_slip}, 64'd0);
        end
        step(2'b11, pat(9), 1'b0);
        check("R4 checked again after wait", {63'd0, rx_slip}, 64'd1);
        for (int k = 0; k < 4; k++) step(2'b01, pat(k), 1'b0);
        check("R3 slip lasts one cycle", {63'd0, rx_slip}, 64'd0);
        for (int k = 0; k < 63; k++) step(2'b10, pat(k), 1'b0);
        check("R2 63 legal headers no lock", {63'd0, out_lock}, 64'd0);
        check("R6 data zero while unaligned", out_data, 64'd0);
        step(2'b11, pat(70), 1'b0);
        check("R3 slip restarts count", {63'd0, rx_slip}, 64'd1);
        for (int k = 0; k < 4; k++) step(2'b01, pat(k), 1'b0);
        for (int k = 0; k < 63; k++) step(2'b01, pat(k + 100), 1'b0);
        check("R3 count restarted, still unaligned", {63'd0, out_lock}, 64'd0);
        step(2'b10, pat(200), 1'b0);
        check("R2 lock after 64th legal header", {63'd0, out_lock}, 64'd1);
        check("R6 R7 data once aligned", out_data, pat(200));
        lk = 0;

        // vector table
        for (int k = 0; k < 8; k++) begin
            step(VEC[k][65:64], VEC[k][63:0], 1'b0);
            check("R7 descrambled payload", out_data, VEC[k][63:0]);
            check("R6 header copy", {62'd0, out_hdr}, {62'd0, VEC[k][65:64]});
            check("R2 lock held", {63'd0, out_lock}, 64'd1);
        end

        // R7 self-synchronization
        step(2'b01, pat(300), 1'b1);
        check("R7 corrupted word follows polynomial", out_data, exp_plain);
        step(2'b01, pat(301), 1'b0);
        check("R7 word after corruption follows polynomial", out_data, exp_plain);
        step(2'b10, pat(302), 1'b0);
        check("R7 resynchronized", out_data, pat(302));

        // R5 window clear, R9 rise
        while (lk % 64 != 0) step(2'b01, pat(lk), 1'b0);
        for (int k = 0; k < 15; k++) step(2'b00, pat(k), 1'b0);
        check("R5 15 errors keep lock", {63'd0, out_lock}, 64'd1);
        check("R9 15 errors no flag", {63'd0, out_hi_ber}, 64'd0);
        for (int k = 0; k < 49; k++) step(2'b10, pat(k), 1'b0);
        step(2'b11, pat(400), 1'b0);
        check("R9 flag after 16th error", {63'd0, out_hi_ber}, 64'd1);
        for (int k = 0; k < 14; k++) step(2'b00, pat(k), 1'b0);
        check("R5 errors over two windows keep lock", {63'd0, out_lock}, 64'd1);
        check("R5 data still flowing", out_data, last_plain);

        // R9 clear at window end
        while (lk < 48827) step(2'b01, pat(lk), 1'b0);
        check("R9 flag held to window end", {63'd0, out_hi_ber}, 64'd1);
        step(2'b01, pat(500), 1'b0);
        check("R9 flag cleared at window end", {63'd0, out_hi_ber}, 64'd0);

        // R5 loss
        while (lk % 64 != 0) step(2'b10, pat(lk), 1'b0);
        for (int k = 0; k < 15; k++) step(2'b00, pat(k), 1'b0);
        check("R5 lock before 16th error", {63'd0, out_lock}, 64'd1);
        step(2'b11, pat(600), 1'b0);
        check("R5 lock lost on 16th error", {63'd0, out_lock}, 64'd0);
        check("R6 data zero after loss", out_data, 64'd0);
        check("R9 flag zero after loss", {63'd0, out_hi_ber}, 64'd0);
        step(2'b00, pat(601), 1'b0);
        check("R3 slip right after loss", {63'd0, rx_slip}, 64'd1);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(5.0 * 190000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule